// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous host and an asynchronous byte-wide static RAM of 512K locations. The host offers one request at a time through a valid/ready handshake: a read, or a write with its data byte. The controller turns each request into a strobe sequence on the memory bus that meets the memory's timing. A read result comes back as a one-cycle response pulse.

Every memory timing figure is a parameter in picoseconds, next to the clock period. The controller converts each figure into a whole number of clock cycles at elaboration. The address and the data byte are registered when a request is accepted. Chip select falls on that same edge. After that, the address can only change again once chip select has returned high.

The bidirectional data pins are modelled as three signals: a separate output byte, an input byte and a driver enable. The controller turns its drivers on only while write enable is low and output enable is high. A turnaround counter also makes sure that output enable has been high for a set number of cycles before the drivers turn on.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, chip select, write enable and output enable are all high (inactive, active-low), the data driver enable is low and the response pulse is low; once reset is released, the block reports ready.
- R2: Ready is high only while no transfer is in progress, and all three strobes are then high. A request presented while ready is low does not change the address or the strobes, and it is never carried out.
- R3: A read accepted on clock edge E0 pulls chip select and output enable low from E0 with the new address. They stay low for three cycles with the default timing (read wait of 2 plus one sample cycle) and are released together. Write enable stays high for the whole read.
- R4: The read byte is taken from the data input at the last edge of the read wait (E2 by default). It is presented with a response pulse that is high for exactly one cycle, starting on the edge where the strobes are released (E3 by default).
- R5: A write accepted on E0 pulls chip select low from E0 while write enable stays high. Write enable is low from E1 to E2 and chip select rises on E3. Output enable stays high for the whole write.
- R6: While chip select stays low, the address output does not change.
- R7: The data driver enable is high only while chip select and write enable are low and output enable is high. Whenever it is high, the data output carries the byte of the current write.
- R8: The data drivers turn on only after output enable has been high for at least the turnaround count (default 1 cycle). When a write directly follows a read, output enable rises at the end of the read and the drivers turn on two edges later with the defaults.
- R9: A byte written to an address is returned by a later read of that address, including at address 0 and at the highest address 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request word address |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Controller idle, request accepted on this edge if valid |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 8 | Read result byte |
| sram_addr | output | 19 | Memory address |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq_out | output | 8 | Data byte driven toward the memory |
| sram_dq_in | input | 8 | Data byte returned by the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |

## Verification
Every strobe and output is a register, so each result is due at a fixed edge counted from the accepting edge E0. For a read, chip select and output enable fall at E0, the byte is captured at E2, and the strobes are released together with the response pulse at E3. For a write, write enable and the drivers are active from E1 to E2 and chip select rises at E3. The bench drives inputs and samples outputs on the falling clock edge, one sample per cycle. It compares each sample with the value due in that cycle, so a strobe that moves one edge early or late fails that cycle's check. Read data is compared against a shadow array in the bench that is updated only by completed write requests. The memory model the controller actually talks to is kept separate from that array.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_SAMPLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctrl_state_t;

  // Whole clock cycles needed to cover an interval, never fewer than one.
  function automatic int cycles_for(input int span_ps, input int clk_ps);
    int n;
    n = (span_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic turn_ok
);

  localparam int GW = $clog2(TURN_CYC + 2);
  localparam logic [GW-1:0] LIMIT = GW'(TURN_CYC);

  logic [GW-1:0] quiet_q;

  // Counts cycles with output enable released, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q <= LIMIT;
    end else if (!oe_n) begin
      quiet_q <= '0;
    end else if (quiet_q < LIMIT) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assign turn_ok = oe_n && (quiet_q >= LIMIT);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PS        = 10000,
  parameter int T_ACCESS_PS   = 10000,
  parameter int T_WPULSE_PS   = 7000,
  parameter int T_DSETUP_PS   = 5000,
  parameter int T_WCYCLE_PS   = 10000,
  parameter int RD_MARGIN_CYC = 1,
  parameter int WR_SETUP_CYC  = 1,
  parameter int TURN_CYC      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int RD_CYC    = cycles_for(T_ACCESS_PS, CLK_PS) + RD_MARGIN_CYC;
  localparam int WP_CYC    = max_of(cycles_for(T_WPULSE_PS, CLK_PS),
                                    cycles_for(T_DSETUP_PS, CLK_PS));
  localparam int RECOV_CYC = max_of(1, cycles_for(T_WCYCLE_PS, CLK_PS)
                                       - WR_SETUP_CYC - WP_CYC);
  localparam int MAX_CYC   = max_of(max_of(RD_CYC, WP_CYC),
                                    max_of(RECOV_CYC, WR_SETUP_CYC));
  localparam int TW        = $clog2(MAX_CYC + 1) + 1;

  localparam logic [TW-1:0] RD_LOAD    = TW'(RD_CYC - 1);
  localparam logic [TW-1:0] SETUP_LOAD = TW'(WR_SETUP_CYC - 1);
  localparam logic [TW-1:0] WP_LOAD    = TW'(WP_CYC - 1);
  localparam logic [TW-1:0] RECOV_LOAD = TW'(RECOV_CYC - 1);

  ctrl_state_t state_q;
  logic        tmr_load;
  logic [TW-1:0] tmr_val;
  logic        tmr_done;
  logic        turn_ok;
  logic        accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Interval selection for the shared countdown.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_load = accept;
        tmr_val  = req_write ? SETUP_LOAD : RD_LOAD;
      end
      ST_WR_SETUP: begin
        tmr_load = tmr_done && turn_ok;
        tmr_val  = WP_LOAD;
      end
      ST_WR_PULSE: begin
        tmr_load = tmr_done;
        tmr_val  = RECOV_LOAD;
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  sram_interval_timer #(.CNT_W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (sram_oe_n),
    .turn_ok (turn_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sram_addr   <= '0;
      sram_cs_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
            sram_cs_n   <= 1'b0;
            if (req_write) begin
              state_q <= ST_WR_SETUP;
            end else begin
              sram_oe_n <= 1'b0;
              state_q   <= ST_RD_ACCESS;
            end
          end
        end
        ST_RD_ACCESS: begin
          if (tmr_done) begin
            rsp_rdata <= sram_dq_in;
            state_q   <= ST_RD_SAMPLE;
          end
        end
        ST_RD_SAMPLE: begin
          sram_cs_n <= 1'b1;
          sram_oe_n <= 1'b1;
          rsp_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_WR_SETUP: begin
          if (tmr_done && turn_ok) begin
            sram_we_n  <= 1'b0;
            sram_dq_oe <= 1'b1;
            state_q    <= ST_WR_PULSE;
          end
        end
        ST_WR_PULSE: begin
          if (tmr_done) begin
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            state_q    <= ST_WR_RECOVER;
          end
        end
        ST_WR_RECOVER: begin
          if (tmr_done) begin
            sram_cs_n <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W   = 19,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  int oe_quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_quiet <= TURN_CYC;
    end else if (!sram_oe_n) begin
      oe_quiet <= 0;
    end else if (oe_quiet < 1000) begin
      oe_quiet <= oe_quiet + 1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid));

  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n));

  // R2
  accept_select_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !sram_cs_n);

  // R3
  read_we_high_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (sram_we_n && !sram_cs_n));

  // R4
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5
  write_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && !sram_cs_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  // R7
  drive_safe_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_we_n && sram_oe_n && !sram_cs_n));

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (oe_quiet >= TURN_CYC));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_cs_n  (sram_cs_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_cs_n;
  logic          sram_we_n;
  logic          sram_oe_n;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in;
  logic          sram_dq_oe;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  logic [DW-1:0] mem    [0:255];
  logic [DW-1:0] shadow [0:255];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_cycle_ctrl dut (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_in  (sram_dq_in),
    .sram_dq_oe  (sram_dq_oe)
  );

  // Memory model: outputs only in read mode, stores while the write strobe is low.
  assign sram_dq_in = (!sram_cs_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : '0;

  always @(posedge clk) begin
    if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[sram_addr[7:0]] <= sram_dq_out;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(posedge clk);
    @(negedge clk);
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1", "strobes in reset",
        {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
    chk(!sram_dq_oe && !rsp_valid, "R1", "driver/rsp in reset",
        {sram_dq_oe, rsp_valid}, 0);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1", "idle strobes",
        {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
  endtask

  // Starts on a falling edge; ends on the falling edge after E3.
  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(req_ready == 1'b1, "R2", "ready before write", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R5", "write setup strobes",
        {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0110);
    chk(sram_addr == a, "R6", "write address", sram_addr, a);
    chk(req_ready == 1'b0, "R2", "busy during write", req_ready, 0);
    @(negedge clk);
    chk(!sram_cs_n && !sram_we_n && sram_oe_n, "R5", "write pulse strobes",
        {sram_cs_n, sram_we_n, sram_oe_n}, 3'b001);
    chk(sram_dq_oe && sram_dq_out == d, "R7", "driven data",
        {sram_dq_oe, sram_dq_out}, {1'b1, d});
    @(negedge clk);
    chk(!sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R5", "write recovery strobes",
        {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0110);
    chk(sram_addr == a, "R6", "address held in recovery", sram_addr, a);
    @(negedge clk);
    chk(sram_cs_n && req_ready, "R5", "write released", {sram_cs_n, req_ready}, 2'b11);
    shadow[a[7:0]] = d;
  endtask

  task automatic t_read(input logic [AW-1:0] a, input bit pulse_chk);
    logic [DW-1:0] exp_d;
    exp_d = shadow[a[7:0]];
    chk(req_ready == 1'b1, "R2", "ready before read", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      chk(!sram_cs_n && !sram_oe_n && sram_we_n, "R3", "read strobes low",
          {sram_cs_n, sram_oe_n, sram_we_n}, 3'b001);
      chk(sram_addr == a && !rsp_valid, "R3", "read address, no rsp yet",
          sram_addr, a);
    end
    @(negedge clk);
    chk(sram_cs_n && sram_oe_n, "R3", "read released", {sram_cs_n, sram_oe_n}, 2'b11);
    chk(rsp_valid == 1'b1, "R4", "rsp pulse at E3", rsp_valid, 1);
    chk(rsp_rdata == exp_d, "R9", "read data", rsp_rdata, exp_d);
    if (pulse_chk) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R4", "rsp single cycle", rsp_valid, 0);
    end
  endtask

  // R4 capture edge: memory changes contents after E2 must not reach the response.
  task automatic t_capture_edge(input logic [AW-1:0] a);
    logic [DW-1:0] exp_d;
    exp_d = shadow[a[7:0]];
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mem[a[7:0]] = ~exp_d;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == exp_d, "R4", "byte taken at E2",
        rsp_rdata, exp_d);
    mem[a[7:0]] = exp_d;
  endtask

  task automatic t_busy_ignore(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [DW-1:0] exp_d;
    exp_d = shadow[a[7:0]];
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = b; req_wdata = 8'h3C;
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      chk(sram_addr == a && sram_we_n && !req_ready, "R2", "busy request ignored",
          sram_addr, a);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == exp_d, "R2", "read unaffected", rsp_rdata, exp_d);
    @(negedge clk);
    t_read(b, 1'b1);
  endtask

  task automatic t_turnaround(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int gap;
    t_read(a, 1'b0);
    gap = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    gap = 1;
    while (!sram_dq_oe && gap < 10) begin
      chk(sram_oe_n == 1'b1, "R8", "output enable off before drive", sram_oe_n, 1);
      @(negedge clk);
      gap++;
    end
    chk(gap == 2, "R8", "edges from read end to drive", gap, 2);
    @(negedge clk);
    @(negedge clk);
    shadow[a[7:0]] = d;
    t_read(a, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i ^ 8'hA5);
      shadow[i] = 8'(i ^ 8'hA5);
    end
    t_reset();
    t_read(19'h00012, 1'b1);
    t_write(19'h00000, 8'h00);
    t_write(19'h7FFFF, 8'hFF);
    t_write(19'h2AB5A, 8'h5A);
    t_read(19'h00000, 1'b1);
    t_read(19'h7FFFF, 1'b1);
    t_read(19'h2AB5A, 1'b1);
    t_write(19'h41033, 8'hC3);
    t_write(19'h41033, 8'h3D);
    t_read(19'h41033, 1'b1);
    t_capture_edge(19'h41033);
    @(negedge clk);
    t_busy_ignore(19'h00044, 19'h12345);
    t_turnaround(19'h55501, 8'h96);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule